// File: doc/BRIEF.md
# Two-Tier Round-Robin Arbiter

This block shares one resource among a set of requesters that are split into a high tier and a low tier. A static membership mask assigns each requester to a tier. When any high-tier requester is asking, the choice is made among the high-tier requesters only. The low tier is considered only when the high tier is silent. Inside each tier, a rotating last-served pointer picks the winner, so every member of a tier gets an equal turn. The arbiter does not limit how often the high tier wins. A busy high tier may therefore keep the low tier waiting for as long as it keeps asking.

The grant is a registered one-hot vector. Once a requester is granted, it keeps the grant until it raises its own end-of-access bit. On that edge the arbiter either loads the next winner straight away or, if nobody is asking, clears the grant and returns to idle. A requester typically holds its request until it sees its grant bit. It then uses the resource and pulses its done bit in the last cycle of its transfer.

Top module: `split_tier_arbiter`

## Requirements
- R1: While reset is low, the grant vector is all zeros, both tier pointers return to index 0, and the arbiter is idle.
- R2: The grant vector never has more than one bit set. A newly loaded grant always goes to a requester whose request bit was high on the loading edge.
- R3: In idle, the first rising edge that sees any request bit high loads a grant, and the grant is visible on `grant_o` right after that edge.
- R4: On every loading edge, a pending high-tier request beats every low-tier request. While high-tier requests never stop, the low tier is not granted.
- R5: Within a tier, the search starts at the index after that tier's last-served index and wraps from N-1 to 0. After reset, the pointer value is 0, so the search begins at index 1.
- R6: A grant stays unchanged until the granted requester raises its own done bit. Done bits of other requesters, and the granted requester dropping its request, have no effect on the grant.
- R7: When the granted requester's done bit is high and some request is pending, the next grant is loaded on that same edge, with no all-zero cycle in between.
- R8: When the granted requester's done bit is high and no request is pending, the grant becomes all zeros on that edge and the arbiter is idle.
- R9: Each tier has its own pointer. A grant to a low-tier requester leaves the high-tier pointer untouched, and a grant to a high-tier requester leaves the low-tier pointer untouched.
- R10: Bit i of the membership mask set to 1 places requester i in the high tier. A 0 places it in the low tier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Request bit per requester |
| done_i | input | N | End-of-access bit per requester; only the granted bit is heeded |
| hi_mask_i | input | N | Tier membership, 1 = high tier |
| grant_o | output | N | Registered one-hot grant, all zeros when idle |

## Verification
Every grant change is due exactly one rising edge after the inputs that cause it. These inputs are a request seen in idle, or the granted requester's done bit. No combinational path reaches `grant_o`. The bench therefore changes inputs on the falling edge, waits for one rising edge, and reads the grant on the next falling edge. Each expected vector is worked out by hand from the tier rule and from the pointer value that the test's own history leaves behind. Tests that depend on pointer history start from reset. Checks of ignored done bits sample the grant after each such cycle, before the true done bit is raised.

// File: rtl/split_tier_pkg.sv
`timescale 1ns/1ps
package split_tier_pkg;

  // Controller phases: nothing granted, or one requester owns the resource.
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_BUSY = 1'b1
  } arb_phase_e;

  // Tier slots used for the per-tier generate arrays.
  localparam int TIER_HI = 0;
  localparam int TIER_LO = 1;
  localparam int TIERS   = 2;

  localparam int DEF_REQS = 8;

endpackage

// File: rtl/tier_rr_pick.sv
`timescale 1ns/1ps
// Rotating search over one tier's candidates, starting after its pointer.
module tier_rr_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] ptr,
  output logic          hit,
  output logic [IW-1:0] win_idx
);

  localparam logic [IW:0] NW = (IW+1)'(N);

  // Index reached k+1 steps after base, wrapped into 0..N-1.
  function automatic logic [IW-1:0] step_idx(input logic [IW-1:0] base, input int k);
    logic [IW:0] s;
    s = {1'b0, base} + (IW+1)'(k) + (IW+1)'(1);
    if (s >= NW) s = s - NW;
    return s[IW-1:0];
  endfunction

  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    for (int k = 0; k < N; k++) begin
      if (!hit && cand[step_idx(ptr, k)]) begin
        hit     = 1'b1;
        win_idx = step_idx(ptr, k);
      end
    end
  end

  always_comb begin
    if (hit) begin
      p_win_is_cand_r5: assert (cand[win_idx]);
    end
  end

endmodule

// File: rtl/tier_ptr.sv
`timescale 1ns/1ps
// Last-served index of one tier.
module tier_ptr #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [IW-1:0] new_idx,
  output logic [IW-1:0] ptr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (upd) ptr <= new_idx;
  end

endmodule

// File: rtl/grant_ctrl.sv
`timescale 1ns/1ps
// Idle/busy controller holding the registered grant.
module grant_ctrl
  import split_tier_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] done,
  input  logic [N-1:0] next_oh,
  output logic [N-1:0] grant,
  output logic         load_evt
);

  arb_phase_e   phase_q, phase_d;
  logic [N-1:0] grant_d;
  logic         any_req;
  logic         finish;
  logic         release_evt;

  assign any_req = |req;
  assign finish  = |(done & grant);

  always_comb begin
    phase_d     = phase_q;
    grant_d     = grant;
    load_evt    = 1'b0;
    release_evt = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (any_req) begin
          load_evt = 1'b1;
          grant_d  = next_oh;
          phase_d  = PH_BUSY;
        end
      end
      PH_BUSY: begin
        if (finish) begin
          if (any_req) begin
            load_evt = 1'b1;
            grant_d  = next_oh;
          end else begin
            release_evt = 1'b1;
            grant_d     = '0;
            phase_d     = PH_IDLE;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      grant   <= '0;
    end else begin
      phase_q <= phase_d;
      grant   <= grant_d;
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && any_req) |=> (grant != '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && (done & grant) == '0) |=> (grant == $past(grant)));

  p_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BUSY && (done & grant) != '0 && any_req) |=> (grant != '0));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> (grant == '0));

  p_idle_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> (grant == '0));

endmodule

// File: rtl/split_tier_arbiter.sv
`timescale 1ns/1ps
// Two-tier arbiter: strict priority between tiers, rotation inside each.
module split_tier_arbiter
  import split_tier_pkg::*;
#(
  parameter int N  = DEF_REQS,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] done_i,
  input  logic [N-1:0] hi_mask_i,
  output logic [N-1:0] grant_o
);

  logic [N-1:0]  tier_cand [TIERS];
  logic [IW-1:0] tier_ptr_q [TIERS];
  logic [IW-1:0] tier_idx [TIERS];
  logic [TIERS-1:0] tier_hit;
  logic [TIERS-1:0] tier_upd;

  logic          sel_hi;
  logic [IW-1:0] sel_idx;
  logic [N-1:0]  next_oh;
  logic          load_evt;

  assign tier_cand[TIER_HI] = req_i & hi_mask_i;
  assign tier_cand[TIER_LO] = req_i & ~hi_mask_i;

  genvar g;
  generate
    for (g = 0; g < TIERS; g++) begin : g_tier
      tier_rr_pick #(.N(N), .IW(IW)) u_pick (
        .cand    (tier_cand[g]),
        .ptr     (tier_ptr_q[g]),
        .hit     (tier_hit[g]),
        .win_idx (tier_idx[g])
      );
      tier_ptr #(.N(N), .IW(IW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (tier_upd[g]),
        .new_idx (tier_idx[g]),
        .ptr     (tier_ptr_q[g])
      );
    end
  endgenerate

  // Strict priority between tiers.
  assign sel_hi  = tier_hit[TIER_HI];
  assign sel_idx = sel_hi ? tier_idx[TIER_HI] : tier_idx[TIER_LO];
  assign next_oh = (tier_hit != '0) ? (N'(1) << sel_idx) : '0;

  // Only the tier that supplied the winner advances its pointer.
  assign tier_upd[TIER_HI] = load_evt & sel_hi;
  assign tier_upd[TIER_LO] = load_evt & ~sel_hi & tier_hit[TIER_LO];

  grant_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_i),
    .done     (done_i),
    .next_oh  (next_oh),
    .grant    (grant_o),
    .load_evt (load_evt)
  );

  p_grant_requested_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> ((grant_o & $past(req_i)) != '0));

  p_hi_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && (req_i & hi_mask_i) != '0) |=> ((grant_o & $past(hi_mask_i)) != '0));

  p_hi_ptr_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(load_evt && sel_hi)) |=> $stable(tier_ptr_q[TIER_HI]));

  p_lo_ptr_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(load_evt && !sel_hi)) |=> $stable(tier_ptr_q[TIER_LO]));

endmodule

// File: tb/split_tier_arbiter_tb.sv
`timescale 1ns/1ps
module split_tier_arbiter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic [7:0] done = '0;
  logic [7:0] mask = 8'hF0;
  logic [7:0] grant;
  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  split_tier_arbiter #(.N(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done),
    .hi_mask_i(mask), .grant_o(grant)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [7:0] r, input logic [7:0] d);
    req  = r;
    done = d;
  endtask

  task automatic chk(input string rq, input logic [7:0] exp);
    nchk++;
    if (grant !== exp) begin
      nfail++;
      $display("FAIL %s grant actual=%b expected=%b", rq, grant, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    mask  = m;
    drive(8'h00, 8'h00);
    tick();
    tick();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(8'hF0);
    chk("R1", 8'h00);
    tick();
    chk("R1", 8'h00);
  endtask

  task automatic t_first_grant();
    do_reset(8'hF0);
    drive(8'h04, 8'h00);
    chk("R3", 8'h00);
    tick();
    chk("R3", 8'h04);
  endtask

  task automatic t_hi_wins();
    do_reset(8'hF0);
    drive(8'h13, 8'h00);
    tick();
    chk("R4", 8'h10);
    for (int i = 0; i < 3; i++) begin
      drive(8'h13, 8'h10);
      tick();
      chk("R4", 8'h10);
    end
    drive(8'h03, 8'h10);
    tick();
    chk("R4", 8'h02);
  endtask

  task automatic t_rotate_hi();
    logic [7:0] seq [4] = '{8'h20, 8'h40, 8'h80, 8'h10};
    logic [7:0] prev;
    do_reset(8'hF0);
    drive(8'hF0, 8'h00);
    tick();
    chk("R5", 8'h10);
    prev = 8'h10;
    for (int i = 0; i < 4; i++) begin
      drive(8'hF0, prev);
      tick();
      chk("R5", seq[i]);
      prev = seq[i];
    end
  endtask

  task automatic t_reset_ptr();
    do_reset(8'hF0);
    drive(8'h03, 8'h00);
    tick();
    chk("R5", 8'h02);
    drive(8'h03, 8'h02);
    tick();
    chk("R5", 8'h01);
    drive(8'h03, 8'h01);
    tick();
    chk("R5", 8'h02);
  endtask

  task automatic t_hold();
    do_reset(8'hF0);
    drive(8'h0C, 8'h00);
    tick();
    chk("R6", 8'h04);
    for (int i = 0; i < 2; i++) begin
      drive(8'h08, 8'h08);
      tick();
      chk("R6", 8'h04);
    end
    drive(8'h08, 8'h04);
    tick();
    chk("R6", 8'h08);
  endtask

  task automatic t_chain();
    do_reset(8'hF0);
    drive(8'h60, 8'h00);
    tick();
    chk("R7", 8'h20);
    drive(8'h60, 8'h20);
    tick();
    chk("R7", 8'h40);
  endtask

  task automatic t_release();
    do_reset(8'hF0);
    drive(8'h80, 8'h00);
    tick();
    chk("R8", 8'h80);
    drive(8'h00, 8'h80);
    tick();
    chk("R8", 8'h00);
    drive(8'h00, 8'h00);
    tick();
    chk("R8", 8'h00);
    drive(8'h01, 8'h00);
    tick();
    chk("R3", 8'h01);
  endtask

  task automatic t_ptr_split();
    do_reset(8'hF0);
    drive(8'h20, 8'h00);
    tick();
    chk("R9", 8'h20);
    drive(8'h02, 8'h20);
    tick();
    chk("R9", 8'h02);
    drive(8'h70, 8'h02);
    tick();
    chk("R9", 8'h40);
  endtask

  task automatic t_mask();
    do_reset(8'h05);
    drive(8'h81, 8'h00);
    tick();
    chk("R10", 8'h01);
    do_reset(8'h80);
    drive(8'h81, 8'h00);
    tick();
    chk("R10", 8'h80);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    t_reset();
    t_first_grant();
    t_hi_wins();
    t_rotate_hi();
    t_reset_ptr();
    t_hold();
    t_chain();
    t_release();
    t_ptr_split();
    t_mask();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule